// File: doc/BRIEF.md
# Configurable Synchronous ROM Read Port

This block is a single-port read-only memory. Its contents come from a fixed function of the address that is evaluated at elaboration, so no initialisation file is needed. The word width and the number of words are parameters. A caller presents an address, and the addressed word appears on `q` after a fixed number of clock edges. The number of edges depends on whether the optional output register is built.

Each register stage has its own clock enable. The address register also has an active-high hold input, which acts as a second, inverted enable and freezes the captured address. An asynchronous active-low clear empties every register at once. A synchronous clear zeroes the register that drives `q`. The read enable can be built or left out. When it is built and zero forcing is selected, an idle read makes `q` all zeros. When zero forcing is not selected, an idle read leaves `q` holding the last word read.

Top module: `cfg_rom_port`

## Requirements
- R1: The word stored at address a (0 <= a < DEPTH) is the low DATA_W bits of ((a*40503 + 0x1234) XOR (a << 5)), computed in 32 bits.
- R2: While in_ce is low, the captured address and the captured read-enable flag hold, and no new word is read. While out_ce is low and OUT_REG=1, q holds its value.
- R3: While addr_hold is high, the address register keeps its previous address even with in_ce high, and a read at that edge returns the word at the kept address.
- R4: With OUT_REG=1, q shows the word two rising edges after its address is sampled. With OUT_REG=0, q shows it one edge after.
- R5: While clr_n is low, the address register, the read-enable flag and q are zero at once, without waiting for a clock edge. q stays zero after release until a read completes.
- R6: sclr high at a rising edge makes q zero after that edge, whatever the clock enables are. With OUT_REG=1, the word held in the first data stage is kept.
- R7: With FORCE_ZERO=1, q is all zeros for a read whose sampled rden was low. This happens with the same latency as data.
- R8: With FORCE_ZERO=0, a cycle with rden low leaves q holding the last word read.
- R9: Priority is clr_n over sclr over the clock enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low, released synchronously |
| sclr | input | 1 | Synchronous clear of the q register |
| in_ce | input | 1 | Clock enable of the address stage |
| out_ce | input | 1 | Clock enable of the output register |
| addr_hold | input | 1 | Freezes the address register when high |
| rden | input | 1 | Read enable (ignored when USE_RDEN=0) |
| addr | input | AW | Read address, AW = $clog2(DEPTH) |
| q | output | DATA_W | Read data |

## Verification
The assertions assume that clr_n is released away from a rising edge and that every address presented is below DEPTH. They also assume that all control inputs carry known values once the clear is released. The bench drives every input shortly after the falling edge and holds it through the next rising edge. It deasserts and reasserts clr_n only at falling edges or mid-cycle. Addresses come from a list bounded by DEPTH-1.

// File: rtl/rom_port_pkg.sv
package rom_port_pkg;

  // Deterministic content generator, evaluated at elaboration.
  function automatic logic [31:0] rom_content(input int unsigned a);
    logic [31:0] v;
    v = (32'(a) * 32'd40503) + 32'h0000_1234;
    return v ^ (32'(a) << 5);
  endfunction

endpackage

// File: rtl/rom_addr_stage.sv
module rom_addr_stage #(
  parameter int AW       = 6,
  parameter bit USE_RDEN = 1'b1
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          in_ce,
  input  logic          addr_hold,
  input  logic          rden,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] look_addr,
  output logic          rd_fire,
  output logic          rd_en_q
);

  logic          rden_eff;
  logic [AW-1:0] addr_d;
  logic          rd_en_d;

  generate
    if (USE_RDEN) begin : g_rden
      assign rden_eff = rden;
    end else begin : g_no_rden
      assign rden_eff = 1'b1;
    end
  endgenerate

  // The address that the array sees during this cycle's edge.
  assign look_addr = addr_hold ? addr_q : addr;
  assign rd_fire   = in_ce & rden_eff;

  always_comb begin
    addr_d  = addr_q;
    rd_en_d = rd_en_q;
    if (in_ce) begin
      rd_en_d = rden_eff;
      if (!addr_hold) begin
        addr_d = addr;
      end
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      addr_q  <= '0;
      rd_en_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      rd_en_q <= rd_en_d;
    end
  end

  // R3: a held address register does not move
  a_r3_hold_keeps_addr: assert property (@(posedge clk) disable iff (!clr_n)
    addr_hold |=> $stable(addr_q));

  // R2: no input enable, no capture
  a_r2_in_ce_idle: assert property (@(posedge clk) disable iff (!clr_n)
    !in_ce |=> ($stable(addr_q) && $stable(rd_en_q)));

  // R5: clear empties the stage
  always @(posedge clk) begin
    if (!clr_n) begin
      a_r5_addr_cleared: assert (addr_q == '0 && rd_en_q == 1'b0);
    end
  end

endmodule

// File: rtl/rom_array.sv
module rom_array #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int AW     = 6
) (
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  import rom_port_pkg::*;

  logic [DATA_W-1:0] table_w [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
      localparam logic [31:0] FULL = rom_content(i);
      assign table_w[i] = FULL[DATA_W-1:0];
    end
  endgenerate

  assign rd_word = (int'(rd_addr) < DEPTH) ? table_w[rd_addr] : '0;

  initial begin
    a_r1_width_fits: assert (DATA_W >= 1 && DATA_W <= 32);
  end

endmodule

// File: rtl/rom_out_stage.sv
module rom_out_stage #(
  parameter int DATA_W     = 16,
  parameter bit OUT_REG    = 1'b1,
  parameter bit FORCE_ZERO = 1'b1
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              sclr,
  input  logic              out_ce,
  input  logic              rd_fire,
  input  logic              rd_en_q,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] data1_q;
  logic [DATA_W-1:0] data1_d;
  logic [DATA_W-1:0] stage1;

  // First data stage: written on a read, cleared by sclr only when it drives q.
  always_comb begin
    data1_d = data1_q;
    if (!OUT_REG && sclr) begin
      data1_d = '0;
    end else if (rd_fire) begin
      data1_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      data1_q <= '0;
    end else begin
      data1_q <= data1_d;
    end
  end

  generate
    if (FORCE_ZERO) begin : g_fz
      assign stage1 = rd_en_q ? data1_q : '0;
    end else begin : g_hold
      assign stage1 = data1_q;
    end
  endgenerate

  generate
    if (OUT_REG) begin : g_oreg
      logic [DATA_W-1:0] q_r;
      logic [DATA_W-1:0] q_d;

      always_comb begin
        q_d = q_r;
        if (sclr) begin
          q_d = '0;
        end else if (out_ce) begin
          q_d = stage1;
        end
      end

      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
          q_r <= '0;
        end else begin
          q_r <= q_d;
        end
      end

      assign q = q_r;

      // R2: output enable low freezes q
      a_r2_out_ce_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (!out_ce && !sclr) |=> $stable(q));

      if (FORCE_ZERO) begin : g_fz_chk
        // R7: idle read gives zero at the output
        a_r7_idle_zero: assert property (@(posedge clk) disable iff (!clr_n)
          (out_ce && !sclr && !rd_en_q) |=> (q == '0));
      end
    end else begin : g_noreg
      assign q = stage1;

      if (!FORCE_ZERO) begin : g_hold_chk
        // R8: without a read q keeps its word
        a_r8_idle_hold: assert property (@(posedge clk) disable iff (!clr_n)
          (!rd_fire && !sclr) |=> $stable(q));
      end
    end
  endgenerate

  // R6, R9: sclr wins over the clock enables
  a_r6_sclr_zero: assert property (@(posedge clk) disable iff (!clr_n)
    sclr |=> (q == '0));

  // R5: clear forces q low without a clock
  always @(posedge clk) begin
    if (!clr_n) begin
      a_r5_q_cleared: assert (q == '0);
    end
  end

endmodule

// File: rtl/cfg_rom_port.sv
module cfg_rom_port #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 64,
  parameter bit OUT_REG    = 1'b1,
  parameter bit FORCE_ZERO = 1'b1,
  parameter bit USE_RDEN   = 1'b1,
  localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              sclr,
  input  logic              in_ce,
  input  logic              out_ce,
  input  logic              addr_hold,
  input  logic              rden,
  input  logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] q
);

  logic [AW-1:0]     addr_q;
  logic [AW-1:0]     look_addr;
  logic              rd_fire;
  logic              rd_en_q;
  logic [DATA_W-1:0] rd_word;

  rom_addr_stage #(
    .AW       (AW),
    .USE_RDEN (USE_RDEN)
  ) u_addr (
    .clk       (clk),
    .clr_n     (clr_n),
    .in_ce     (in_ce),
    .addr_hold (addr_hold),
    .rden      (rden),
    .addr      (addr),
    .addr_q    (addr_q),
    .look_addr (look_addr),
    .rd_fire   (rd_fire),
    .rd_en_q   (rd_en_q)
  );

  rom_array #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .AW     (AW)
  ) u_array (
    .rd_addr (look_addr),
    .rd_word (rd_word)
  );

  rom_out_stage #(
    .DATA_W     (DATA_W),
    .OUT_REG    (OUT_REG),
    .FORCE_ZERO (FORCE_ZERO && USE_RDEN)
  ) u_out (
    .clk     (clk),
    .clr_n   (clr_n),
    .sclr    (sclr),
    .out_ce  (out_ce),
    .rd_fire (rd_fire),
    .rd_en_q (rd_en_q),
    .rd_word (rd_word),
    .q       (q)
  );

  // R3: a held address drives the array lookup
  a_r3_lookup_kept: assert property (@(posedge clk) disable iff (!clr_n)
    addr_hold |-> (look_addr == addr_q));

  // R6: sclr does not reach the address register
  a_r6_sclr_keeps_addr: assert property (@(posedge clk) disable iff (!clr_n)
    (sclr && !in_ce) |=> $stable(addr_q));

endmodule

// File: tb/cfg_rom_port_tb.sv
`timescale 1ns/1ps
module cfg_rom_port_tb;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 64;
  localparam int AW     = 6;

  logic              clk = 1'b0;
  logic              clr_n;
  logic              sclr;
  logic              in_ce;
  logic              out_ce;
  logic              addr_hold;
  logic              rden;
  logic [AW-1:0]     addr;
  logic [DATA_W-1:0] q;
  logic [DATA_W-1:0] q1;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  cfg_rom_port #(
    .DATA_W (DATA_W), .DEPTH (DEPTH), .OUT_REG (1'b1),
    .FORCE_ZERO (1'b1), .USE_RDEN (1'b1)
  ) u_dut (
    .clk (clk), .clr_n (clr_n), .sclr (sclr), .in_ce (in_ce),
    .out_ce (out_ce), .addr_hold (addr_hold), .rden (rden),
    .addr (addr), .q (q)
  );

  cfg_rom_port #(
    .DATA_W (DATA_W), .DEPTH (DEPTH), .OUT_REG (1'b0),
    .FORCE_ZERO (1'b0), .USE_RDEN (1'b1)
  ) u_dut_lat1 (
    .clk (clk), .clr_n (clr_n), .sclr (sclr), .in_ce (in_ce),
    .out_ce (out_ce), .addr_hold (addr_hold), .rden (rden),
    .addr (addr), .q (q1)
  );

  function automatic logic [DATA_W-1:0] exp_word(input int a);
    logic [31:0] m;
    m = (32'(a) * 32'd40503) + 32'h1234;
    m = m ^ (32'(a) << 5);
    return m[DATA_W-1:0];
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle_inputs();
    sclr = 0; in_ce = 1; out_ce = 1; addr_hold = 0; rden = 1; addr = '0;
  endtask

  // Read one address on both instances; leaves inputs at that address.
  task automatic load(input int a);
    addr = AW'(a); rden = 1; in_ce = 1; out_ce = 1; addr_hold = 0;
    edges(2);
  endtask

  task automatic t_reset();
    clr_n = 0; idle_inputs();
    edges(2);
    check("R5 reset q", q, '0);
    check("R5 reset q lat1", q1, '0);
    clr_n = 1;
    #0.5;
    check("R5 q after release", q, '0);
  endtask

  task automatic t_sweep();
    int list [6] = '{0, 1, 17, 32, 42, DEPTH-1};
    foreach (list[k]) begin
      addr = AW'(list[k]); rden = 1;
      edges(1);
      check("R4 lat1 one edge", q1, exp_word(list[k]));
      edges(1);
      check("R1 word", q, exp_word(list[k]));
    end
  endtask

  task automatic t_pipeline();
    int seq [5] = '{5, 60, 7, 33, 12};
    for (int i = 0; i < 7; i++) begin
      if (i < 5) addr = AW'(seq[i]);
      edges(1);
      if (i < 5)  check("R4 lat1 stream", q1, exp_word(seq[i]));
      if (i >= 1 && i < 6) check("R4 two-edge stream", q, exp_word(seq[i-1]));
    end
  endtask

  task automatic t_hold();
    load(9);
    addr_hold = 1; addr = AW'(50);
    edges(2);
    check("R3 held addr", q, exp_word(9));
    check("R3 held addr lat1", q1, exp_word(9));
    addr_hold = 0;
    edges(2);
    check("R3 released", q, exp_word(50));
  endtask

  task automatic t_in_ce();
    load(21);
    in_ce = 0; addr = AW'(3);
    edges(3);
    check("R2 in_ce low", q, exp_word(21));
    check("R2 in_ce low lat1", q1, exp_word(21));
    in_ce = 1;
    edges(2);
    check("R2 in_ce back", q, exp_word(3));
  endtask

  task automatic t_out_ce();
    load(11);
    out_ce = 0; addr = AW'(44);
    edges(2);
    check("R2 out_ce lat1 moves", q1, exp_word(44));
    check("R2 out_ce low holds", q, exp_word(11));
    out_ce = 1;
    edges(1);
    check("R2 out_ce back", q, exp_word(44));
  endtask

  task automatic t_idle_read();
    load(27);
    rden = 0; addr = AW'(2);
    edges(1);
    check("R7 same latency", q, exp_word(27));
    check("R8 lat1 hold", q1, exp_word(27));
    edges(1);
    check("R7 forced zero", q, '0);
    check("R8 lat1 still hold", q1, exp_word(27));
    rden = 1;
    edges(2);
    check("R7 read again", q, exp_word(2));
  endtask

  task automatic t_sclr();
    load(38);
    sclr = 1; in_ce = 0; out_ce = 0;
    edges(1);
    check("R6 sclr q", q, '0);
    check("R9 sclr over ce lat1", q1, '0);
    sclr = 0; out_ce = 1;
    edges(1);
    check("R6 first stage kept", q, exp_word(38));
    in_ce = 1;
  endtask

  task automatic t_async();
    load(55);
    @(posedge clk); #1;
    clr_n = 0; sclr = 1;
    #0.5;
    check("R5 async q", q, '0);
    check("R5 async q lat1", q1, '0);
    @(negedge clk);
    sclr = 0;
    edges(1);
    check("R9 clear over sclr", q, '0);
    clr_n = 1;
    edges(1);
    check("R5 after clear lat1", q1, exp_word(55));
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr_n = 0; idle_inputs();
    @(negedge clk);
    t_reset();
    t_sweep();
    t_pipeline();
    t_hold();
    t_in_ce();
    t_out_ce();
    t_idle_read();
    t_sclr();
    t_async();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule